// File: doc/BRIEF.md
# Flash Erase Command Sequencer

This block is the command front end of a parallel NOR flash array. It watches bus write cycles (address plus data byte) and turns the legal sequences into erase, program, suspend, resume and reset actions. An erase job goes to a simple program/erase controller that models the array with cycle counters. The block reports which mode the device is in and which blocks are marked for erase.

A chip erase needs six writes: two unlock cycles, the setup code, two more unlock cycles, then the chip confirm. A block erase uses the same prefix but ends with a block confirm written inside the target block. That confirm opens a timeout window. During the window each further block confirm adds its block and restarts the window, with no unlock cycles needed. The erase begins only once the window runs out. A block erase can be suspended, and a program can run while it is suspended, as long as the program targets a block that is not being erased. The erase then continues from where it stopped.

The unlock addresses depend on a width-mode input. In byte-wide mode the first unlock address is AAAh and the second is 555h. In word-wide mode they are 555h and 2AAh. Only the low 12 address bits are compared. The block index is taken from the top `BLK_W` address bits.

Top module: `flash_erase_seq`

## Requirements
- R1: After reset, `mode_o` is 0 and `blk_sel_o` is 0. The mode codes are: 0 read array, 1 timeout window, 2 erasing, 3 suspended, 4 programming, 5 failed. No other value is ever output.
- R2: The sequence is AAh at the first unlock address, 55h at the second, 80h at the first, AAh at the first, 55h at the second, then 10h at the first. It starts a chip erase, and the mode becomes 2 with every block selected on the sixth write. After ERS_CYC clock cycles the mode returns to 0 and the selection clears. The unlock addresses follow `word_mode`: AAAh/555h when it is 0, 555h/2AAh when it is 1.
- R3: A wrong data value or wrong address on any unlock cycle abandons the sequence. So does a final code that is neither 10h nor 30h. The mode stays 0, and a following lone confirm write has no effect.
- R4: The unlock/setup prefix followed by 30h at an address inside block b enters mode 1 with only bit b selected. In mode 1, each write of 30h adds the block it addresses and restarts the window. Erasing (mode 2) begins TMO_CYC cycles after the last such write.
- R5: In mode 1, a write of any value other than 30h or B0h cancels the job: the mode becomes 0 and the selection clears.
- R6: In mode 2, the only write with any effect is B0h during a block erase. B0h during a chip erase is ignored, and so are all other writes. The selection holds until the erase finishes.
- R7: B0h in mode 2 (block erase) or in mode 1 gives mode 3. The erase count freezes, or the window ends without the erase having started. In mode 3, a write of 30h (no unlock pending) returns to mode 2. The erase then runs for its remaining cycles, or for the full ERS_CYC if it never started.
- R8: In mode 3, the sequence AAh/55h/A0h followed by a target write starts a program of PROG_CYC cycles (mode 4, then back to mode 3), but only if the target block is not selected. A target inside a selected block is dropped and the mode stays 3. In mode 3, F0h, B0h and the erase setup prefix have no effect. The selection does not change in mode 4.
- R9: If `pe_fail_i` is high when an erase completes, the mode becomes 5 and the selection is kept. In mode 5, only F0h (any address) has an effect: it returns the mode to 0 and clears the selection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Bus write strobe, one cycle per write |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | 8 | Write data / command code |
| word_mode | input | 1 | 1 selects word-wide unlock addresses |
| pe_fail_i | input | 1 | Array verify failure flag, sampled at erase completion |
| mode_o | output | 3 | Current mode code (see R1) |
| blk_sel_o | output | 2**BLK_W | Blocks selected for erase |

## Verification
A wrong unlock stage shows up on the write that would complete or abandon a sequence: `mode_o` is wrong on the very next sample, either a missed entry into mode 2/1 or a spurious one. A wrong window or erase counter shows up as a mode change that is one or more cycles early or late. The checks therefore sample on the exact cycle each count expires, and one cycle before it. A counter that is not frozen during suspend makes the resumed erase end early, which the resume checks catch. A corrupted selection mask is visible on `blk_sel_o` straight away.

// File: rtl/fes_pkg.sv
package fes_pkg;
  typedef enum logic [2:0] {
    MD_READ  = 3'd0,
    MD_WIN   = 3'd1,
    MD_ERASE = 3'd2,
    MD_SUSP  = 3'd3,
    MD_PROG  = 3'd4,
    MD_FAIL  = 3'd5
  } mode_t;

  localparam logic [7:0] C_UNLK1   = 8'hAA;
  localparam logic [7:0] C_UNLK2   = 8'h55;
  localparam logic [7:0] C_ESETUP  = 8'h80;
  localparam logic [7:0] C_PSETUP  = 8'hA0;
  localparam logic [7:0] C_CHIP    = 8'h10;
  localparam logic [7:0] C_BLKRES  = 8'h30;
  localparam logic [7:0] C_SUSPEND = 8'hB0;
  localparam logic [7:0] C_RESET   = 8'hF0;
endpackage

// File: rtl/fes_unlock.sv
module fes_unlock
  import fes_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        en,
  input  logic [11:0] addr_lo,
  input  logic [7:0]  data,
  input  logic        word_mode,
  input  logic        allow_erase,
  input  logic        allow_prog,
  output logic        busy,
  output logic        ev_chip,
  output logic        ev_block,
  output logic        ev_prog
);
  typedef enum logic [2:0] {
    U_IDLE, U_C1, U_C2, U_E3, U_E4, U_E5, U_PA
  } ustate_t;

  ustate_t st_q, st_d;
  logic at_first, at_second;

  assign at_first  = addr_lo == (word_mode ? 12'h555 : 12'hAAA);
  assign at_second = addr_lo == (word_mode ? 12'h2AA : 12'h555);
  assign busy      = st_q != U_IDLE;

  always_comb begin
    st_d     = st_q;
    ev_chip  = 1'b0;
    ev_block = 1'b0;
    ev_prog  = 1'b0;
    if (en) begin
      if (st_q == U_PA) begin
        ev_prog = 1'b1;
        st_d    = U_IDLE;
      end else if (data == C_RESET) begin
        st_d = U_IDLE;
      end else begin
        st_d = U_IDLE;
        case (st_q)
          U_IDLE: if (data == C_UNLK1 && at_first)  st_d = U_C1;
          U_C1:   if (data == C_UNLK2 && at_second) st_d = U_C2;
          U_C2: begin
            if (data == C_ESETUP && at_first && allow_erase) st_d = U_E3;
            else if (data == C_PSETUP && at_first && allow_prog) st_d = U_PA;
          end
          U_E3:   if (data == C_UNLK1 && at_first)  st_d = U_E4;
          U_E4:   if (data == C_UNLK2 && at_second) st_d = U_E5;
          U_E5: begin
            if (data == C_CHIP && at_first) ev_chip = 1'b1;
            else if (data == C_BLKRES)      ev_block = 1'b1;
          end
          default: st_d = U_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) st_q <= U_IDLE;
    else     st_q <= st_d;
  end
endmodule

// File: rtl/fes_countdown.sv
module fes_countdown #(
  parameter int unsigned LOAD_VAL = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  input  logic run,
  output logic done
);
  localparam int unsigned CW = $clog2(LOAD_VAL + 1);

  logic [CW-1:0] cnt_q;

  assign done = run && (cnt_q == CW'(1));

  always_ff @(posedge clk) begin
    if (rst)                          cnt_q <= '0;
    else if (load)                    cnt_q <= CW'(LOAD_VAL);
    else if (run && cnt_q != '0)      cnt_q <= cnt_q - CW'(1);
  end
endmodule

// File: rtl/flash_erase_seq.sv
module flash_erase_seq
  import fes_pkg::*;
#(
  parameter int unsigned ADDR_W   = 20,
  parameter int unsigned BLK_W    = 4,
  parameter int unsigned TMO_CYC  = 50000,
  parameter int unsigned ERS_CYC  = 100000,
  parameter int unsigned PROG_CYC = 200
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_en,
  input  logic [ADDR_W-1:0]     wr_addr,
  input  logic [7:0]            wr_data,
  input  logic                  word_mode,
  input  logic                  pe_fail_i,
  output logic [2:0]            mode_o,
  output logic [(1<<BLK_W)-1:0] blk_sel_o
);
  localparam int unsigned NBLK = 1 << BLK_W;

  mode_t           mode_q, mode_d;
  logic [NBLK-1:0] sel_q, sel_d, blk_hot;
  logic            chip_q, chip_d, started_q, started_d;
  logic            tmo_load, ers_load, prg_load;
  logic            tmo_done, ers_done, prg_done;
  logic            unl_en, unl_busy, ev_chip, ev_block, ev_prog;
  logic [BLK_W-1:0] blk_idx;

  assign blk_idx = wr_addr[ADDR_W-1 -: BLK_W];
  assign blk_hot = NBLK'(1) << blk_idx;
  assign unl_en  = wr_en && (mode_q == MD_READ || mode_q == MD_SUSP);

  fes_unlock u_unlock (
    .clk         (clk),
    .rst         (rst),
    .en          (unl_en),
    .addr_lo     (wr_addr[11:0]),
    .data        (wr_data),
    .word_mode   (word_mode),
    .allow_erase (mode_q == MD_READ),
    .allow_prog  (mode_q == MD_SUSP),
    .busy        (unl_busy),
    .ev_chip     (ev_chip),
    .ev_block    (ev_block),
    .ev_prog     (ev_prog)
  );

  fes_countdown #(.LOAD_VAL(TMO_CYC)) u_window (
    .clk (clk), .rst (rst), .load (tmo_load),
    .run (mode_q == MD_WIN), .done (tmo_done)
  );

  fes_countdown #(.LOAD_VAL(ERS_CYC)) u_erase (
    .clk (clk), .rst (rst), .load (ers_load),
    .run (mode_q == MD_ERASE), .done (ers_done)
  );

  fes_countdown #(.LOAD_VAL(PROG_CYC)) u_prog (
    .clk (clk), .rst (rst), .load (prg_load),
    .run (mode_q == MD_PROG), .done (prg_done)
  );

  always_comb begin
    mode_d    = mode_q;
    sel_d     = sel_q;
    chip_d    = chip_q;
    started_d = started_q;
    tmo_load  = 1'b0;
    ers_load  = 1'b0;
    prg_load  = 1'b0;
    case (mode_q)
      MD_READ: begin
        if (ev_chip) begin
          mode_d    = MD_ERASE;
          sel_d     = '1;
          chip_d    = 1'b1;
          started_d = 1'b1;
          ers_load  = 1'b1;
        end else if (ev_block) begin
          mode_d    = MD_WIN;
          sel_d     = blk_hot;
          chip_d    = 1'b0;
          started_d = 1'b0;
          tmo_load  = 1'b1;
        end
      end
      MD_WIN: begin
        if (tmo_done) begin
          mode_d    = MD_ERASE;
          started_d = 1'b1;
          ers_load  = 1'b1;
        end else if (wr_en) begin
          if (wr_data == C_BLKRES) begin
            sel_d    = sel_q | blk_hot;
            tmo_load = 1'b1;
          end else if (wr_data == C_SUSPEND) begin
            mode_d = MD_SUSP;
          end else begin
            mode_d = MD_READ;
            sel_d  = '0;
          end
        end
      end
      MD_ERASE: begin
        if (ers_done) begin
          chip_d = 1'b0;
          if (pe_fail_i) begin
            mode_d = MD_FAIL;
          end else begin
            mode_d = MD_READ;
            sel_d  = '0;
          end
        end else if (wr_en && wr_data == C_SUSPEND && !chip_q) begin
          mode_d = MD_SUSP;
        end
      end
      MD_SUSP: begin
        if (ev_prog) begin
          if ((blk_hot & sel_q) == '0) begin
            mode_d   = MD_PROG;
            prg_load = 1'b1;
          end
        end else if (wr_en && !unl_busy && wr_data == C_BLKRES) begin
          mode_d = MD_ERASE;
          if (!started_q) begin
            started_d = 1'b1;
            ers_load  = 1'b1;
          end
        end
      end
      MD_PROG: begin
        if (prg_done) mode_d = MD_SUSP;
      end
      MD_FAIL: begin
        if (wr_en && wr_data == C_RESET) begin
          mode_d = MD_READ;
          sel_d  = '0;
        end
      end
      default: begin
        mode_d = MD_READ;
        sel_d  = '0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q    <= MD_READ;
      sel_q     <= '0;
      chip_q    <= 1'b0;
      started_q <= 1'b0;
    end else begin
      mode_q    <= mode_d;
      sel_q     <= sel_d;
      chip_q    <= chip_d;
      started_q <= started_d;
    end
  end

  assign mode_o    = mode_q;
  assign blk_sel_o = sel_q;
endmodule

// File: rtl/fes_chk.sv
module fes_chk
  import fes_pkg::*;
#(
  parameter int unsigned NBLK = 16
) (
  input logic            clk,
  input logic            rst,
  input logic            wr_en,
  input logic [7:0]      wr_data,
  input logic [2:0]      mode_o,
  input logic [NBLK-1:0] blk_sel_o
);
  // R1
  legal_mode_chk: assert property (@(posedge clk) disable iff (rst)
    mode_o <= 3'd5);

  // R5
  read_clear_chk: assert property (@(posedge clk) disable iff (rst)
    mode_o == 3'(MD_READ) |-> blk_sel_o == '0);

  // R4
  window_sel_chk: assert property (@(posedge clk) disable iff (rst)
    mode_o == 3'(MD_WIN) |-> blk_sel_o != '0);

  // R7
  susp_entry_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_o == 3'(MD_SUSP) && $past(mode_o) != 3'(MD_SUSP)) |->
      ($past(mode_o) == 3'(MD_WIN) || $past(mode_o) == 3'(MD_ERASE) ||
       $past(mode_o) == 3'(MD_PROG)));

  // R6
  erase_exit_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(mode_o) == 3'(MD_ERASE) && mode_o != 3'(MD_ERASE)) |->
      (mode_o == 3'(MD_READ) || mode_o == 3'(MD_FAIL) || mode_o == 3'(MD_SUSP)));

  // R8
  prog_sel_chk: assert property (@(posedge clk) disable iff (rst)
    mode_o == 3'(MD_PROG) |=> $stable(blk_sel_o));

  // R9
  fail_exit_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(mode_o) == 3'(MD_FAIL) && mode_o != 3'(MD_FAIL)) |->
      (mode_o == 3'(MD_READ) && $past(wr_en) && $past(wr_data) == C_RESET));
endmodule

bind flash_erase_seq fes_chk #(.NBLK(1 << BLK_W)) u_fes_chk (
  .clk       (clk),
  .rst       (rst),
  .wr_en     (wr_en),
  .wr_data   (wr_data),
  .mode_o    (mode_o),
  .blk_sel_o (blk_sel_o)
);

// File: tb/test_flash_erase_seq.sv
module test_flash_erase_seq;
  localparam int ADDR_W = 20;
  localparam int BLK_W  = 4;
  localparam int TMO    = 8;
  localparam int ERS    = 20;
  localparam int PRG    = 5;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              wr_en = 1'b0;
  logic [ADDR_W-1:0] wr_addr = '0;
  logic [7:0]        wr_data = '0;
  logic              word_mode = 1'b0;
  logic              pe_fail_i = 1'b0;
  logic [2:0]        mode_o;
  logic [15:0]       blk_sel_o;

  int n_chk = 0;
  int n_err = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  flash_erase_seq #(
    .ADDR_W(ADDR_W), .BLK_W(BLK_W), .TMO_CYC(TMO), .ERS_CYC(ERS), .PROG_CYC(PRG)
  ) i_flash_erase_seq (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .word_mode(word_mode), .pe_fail_i(pe_fail_i), .mode_o(mode_o), .blk_sel_o(blk_sel_o)
  );

  function automatic logic [ADDR_W-1:0] ba(input int b, input logic [11:0] lo);
    return {4'(b), 4'h0, lo};
  endfunction

  function automatic logic [11:0] a1();
    return word_mode ? 12'h555 : 12'hAAA;
  endfunction

  function automatic logic [11:0] a2();
    return word_mode ? 12'h2AA : 12'h555;
  endfunction

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [2:0] em, input logic [15:0] es);
    n_chk++;
    if (mode_o !== em || blk_sel_o !== es) begin
      n_err++;
      $display("FAIL %s: mode=%0d sel=%h expected mode=%0d sel=%h", req, mode_o, blk_sel_o, em, es);
    end
  endtask

  task automatic prefix();
    wr(ba(0, a1()), 8'hAA); wr(ba(0, a2()), 8'h55); wr(ba(0, a1()), 8'h80);
    wr(ba(0, a1()), 8'hAA); wr(ba(0, a2()), 8'h55);
  endtask

  task automatic block_cmd(input int b);
    prefix();
    wr(ba(b, 12'h000), 8'h30);
  endtask

  task automatic t_reset();
    check("R1 reset state", 3'd0, 16'h0000);
  endtask

  task automatic t_chip_byte();
    word_mode = 1'b0;
    prefix();
    check("R2 no erase before sixth cycle", 3'd0, 16'h0000);
    wr(ba(0, 12'hAAA), 8'h10);
    check("R2 chip erase starts byte mode", 3'd2, 16'hFFFF);
    idle(ERS - 1);
    check("R2 chip erase still running", 3'd2, 16'hFFFF);
    idle(1);
    check("R2 chip erase done", 3'd0, 16'h0000);
  endtask

  task automatic t_chip_word();
    word_mode = 1'b1;
    wr(ba(0, 12'hAAA), 8'hAA); wr(ba(0, 12'h555), 8'h55); wr(ba(0, 12'hAAA), 8'h80);
    wr(ba(0, 12'hAAA), 8'hAA); wr(ba(0, 12'h555), 8'h55); wr(ba(0, 12'hAAA), 8'h10);
    check("R2 byte addresses ignored in word mode", 3'd0, 16'h0000);
    prefix();
    wr(ba(0, 12'h555), 8'h10);
    check("R2 chip erase starts word mode", 3'd2, 16'hFFFF);
    // R6 suspend ignored during chip erase
    wr(ba(3, 12'h000), 8'hB0);
    check("R6 suspend ignored in chip erase", 3'd2, 16'hFFFF);
    idle(ERS - 1);
    check("R2 word chip erase done", 3'd0, 16'h0000);
    word_mode = 1'b0;
  endtask

  task automatic t_abort();
    wr(ba(0, 12'hAAA), 8'hAA); wr(ba(0, 12'hAAA), 8'h55);
    wr(ba(0, 12'hAAA), 8'h80); wr(ba(0, 12'hAAA), 8'hAA); wr(ba(0, 12'h555), 8'h55);
    wr(ba(0, 12'hAAA), 8'h10);
    check("R3 bad second unlock address", 3'd0, 16'h0000);
    prefix();
    wr(ba(2, 12'h000), 8'h20);
    check("R3 bad confirm code", 3'd0, 16'h0000);
    wr(ba(2, 12'h000), 8'h30);
    check("R3 lone confirm ignored", 3'd0, 16'h0000);
    wr(ba(0, 12'hAAA), 8'hAA); wr(ba(0, 12'h555), 8'h55); wr(ba(0, 12'hAAA), 8'h80);
    wr(ba(0, 12'hAAA), 8'h55);
    wr(ba(0, 12'hAAA), 8'h10);
    check("R3 bad fourth cycle", 3'd0, 16'h0000);
  endtask

  task automatic t_block_stack();
    block_cmd(2);
    check("R4 window opens", 3'd1, 16'h0004);
    idle(5);
    wr(ba(5, 12'h123), 8'h30);
    check("R4 block added", 3'd1, 16'h0024);
    idle(TMO - 1);
    check("R4 window restarted", 3'd1, 16'h0024);
    idle(1);
    check("R4 erase begins after window", 3'd2, 16'h0024);
    idle(ERS);
    check("R4 block erase done", 3'd0, 16'h0000);
  endtask

  task automatic t_window_cancel();
    block_cmd(3);
    wr(ba(1, 12'h000), 8'h40);
    check("R5 window cancelled", 3'd0, 16'h0000);
    idle(TMO + 2);
    check("R5 no erase after cancel", 3'd0, 16'h0000);
  endtask

  task automatic t_erase_ignores();
    block_cmd(2);
    idle(TMO);
    check("R6 erasing", 3'd2, 16'h0004);
    wr(ba(0, 12'hAAA), 8'hF0);
    wr(ba(7, 12'h000), 8'h30);
    wr(ba(0, 12'hAAA), 8'hAA);
    check("R6 writes ignored while erasing", 3'd2, 16'h0004);
    idle(ERS - 4);
    check("R6 erase not shortened", 3'd2, 16'h0004);
    idle(1);
    check("R6 erase completes", 3'd0, 16'h0000);
  endtask

  task automatic t_suspend_resume();
    block_cmd(6);
    idle(TMO);
    idle(4);
    wr(ba(9, 12'h000), 8'hB0);
    check("R7 suspended", 3'd3, 16'h0040);
    idle(30);
    check("R7 stays suspended", 3'd3, 16'h0040);
    wr(ba(11, 12'h000), 8'h30);
    check("R7 resumed", 3'd2, 16'h0040);
    idle(ERS - 6);
    check("R7 remaining cycles run", 3'd2, 16'h0040);
    idle(1);
    check("R7 resumed erase done", 3'd0, 16'h0000);
  endtask

  task automatic t_suspend_window();
    block_cmd(1);
    idle(3);
    wr(ba(0, 12'h000), 8'hB0);
    check("R7 suspend in window", 3'd3, 16'h0002);
    idle(TMO + 2);
    check("R7 window ended by suspend", 3'd3, 16'h0002);
    wr(ba(0, 12'h000), 8'h30);
    check("R7 resume starts erase", 3'd2, 16'h0002);
    idle(ERS - 1);
    check("R7 full erase after resume", 3'd2, 16'h0002);
    idle(1);
    check("R7 erase from window done", 3'd0, 16'h0000);
  endtask

  task automatic t_prog_in_susp();
    block_cmd(4);
    idle(TMO);
    wr(ba(0, 12'h000), 8'hB0);
    check("R8 suspended", 3'd3, 16'h0010);
    wr(ba(0, 12'hAAA), 8'hF0);
    wr(ba(0, 12'hAAA), 8'hB0);
    check("R8 reset and suspend ignored", 3'd3, 16'h0010);
    wr(ba(0, 12'hAAA), 8'hAA); wr(ba(0, 12'h555), 8'h55); wr(ba(0, 12'hAAA), 8'h80);
    check("R8 erase setup ignored", 3'd3, 16'h0010);
    wr(ba(0, 12'hAAA), 8'hAA); wr(ba(0, 12'h555), 8'h55); wr(ba(0, 12'hAAA), 8'hA0);
    wr(ba(4, 12'h010), 8'h5A);
    check("R8 program to erasing block dropped", 3'd3, 16'h0010);
    wr(ba(0, 12'hAAA), 8'hAA); wr(ba(0, 12'h555), 8'h55); wr(ba(0, 12'hAAA), 8'hA0);
    wr(ba(9, 12'h010), 8'h5A);
    check("R8 program starts", 3'd4, 16'h0010);
    idle(PRG - 1);
    check("R8 program running", 3'd4, 16'h0010);
    idle(1);
    check("R8 program back to suspend", 3'd3, 16'h0010);
    wr(ba(0, 12'h000), 8'h30);
    idle(ERS - 2);
    check("R8 erase resumed", 3'd2, 16'h0010);
    idle(1);
    check("R8 erase finishes", 3'd0, 16'h0000);
  endtask

  task automatic t_fail();
    pe_fail_i = 1'b1;
    block_cmd(0);
    idle(TMO + ERS);
    check("R9 failure reported", 3'd5, 16'h0001);
    pe_fail_i = 1'b0;
    wr(ba(0, 12'h000), 8'hB0);
    wr(ba(0, 12'hAAA), 8'hAA);
    wr(ba(0, 12'h000), 8'h30);
    check("R9 only reset leaves failure", 3'd5, 16'h0001);
    wr(ba(5, 12'h000), 8'hF0);
    check("R9 reset clears failure", 3'd0, 16'h0000);
  endtask

  task automatic report();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    idle(3);
    rst = 1'b0;
    idle(1);
    t_reset();
    t_chip_byte();
    t_chip_word();
    t_abort();
    t_block_stack();
    t_window_cancel();
    t_erase_ignores();
    t_suspend_resume();
    t_suspend_window();
    t_prog_in_susp();
    t_fail();
    finished = 1;
    report();
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: run did not finish, expected completion");
      report();
    end
  end
endmodule